// File: doc/BRIEF.md
# Debounced Event Flag with Latch

This block sits behind a window comparator in a sensor data path. Every sample period, the comparator gives it one combined boolean condition, a hit bit per axis and a polarity bit per axis. The block debounces the condition with a programmable count and drives an event-active flag. It also holds a reported copy of the per-axis hit and polarity bits, which the host reads out. Every input is qualified by a single-cycle sample strobe. A read-clear pulse comes from the host's status read, and a mode-change pulse comes from the power-state controller.

The debounce count has two behaviours for a false sample. In the decrement behaviour, the count steps down by one, so the event drops only after the condition has been false for the programmed count plus one samples. In the clear behaviour, the count returns to zero at once. In latched mode, the event flag and the reported hits hold until the host reads them. A fresh event then needs the condition to go false and come back.

A keep-awake pulse tells the power controller that an event is still active on a given sample.

Top module: `dbnc_event_flag`

## Requirements
- R1: With debounce count N, `event_act` rises on the clock edge that takes the Nth consecutive true sample; N of 0 or 1 both set on the first true sample.
- R2: With `dbc_clear_mode`=0 and latching off, each true sample raises the internal count by one, up to N and no higher, and each false sample lowers it by one. After an event, `event_act` falls on the (N+1)th consecutive false sample.
- R3: With `dbc_clear_mode`=1 and latching off, a single false sample drops `event_act` and zeroes the count, so a new event again needs N true samples.
- R4: With `latch_en`=1, `event_act` stays high through false samples until a `rd_clr` pulse. After that pulse it rises again only once a false sample has been taken and the count is reached again.
- R5: With `latch_en`=1, `axis_flag_out` is OR-ed with `axis_hit` on every event set and clears only on `rd_clr`. With `latch_en`=0, `rd_clr` changes neither `event_act` nor `axis_flag_out`.
- R6: With `latch_en`=0, `axis_flag_out` loads `axis_hit` on each sample that sets or re-confirms the event, and on every sample when N is 0.
- R7: Bit i of `axis_pol_out` loads `axis_pol_in[i]` only on the edge where bit i of `axis_flag_out` goes from 0 to 1, and holds while that flag stays 1.
- R8: A `mode_chg` pulse zeroes the debounce count. If it coincides with a sample strobe, that sample is not counted and cannot set the event.
- R9: With `wake_en`=1, `wake_rst` is high for exactly one cycle after each sample strobe taken while `event_act` was already high; it stays low otherwise.
- R10: When `rd_clr` and an event set occur in the same clock in latched mode, the set wins: `event_act` is 1 and the new hits are kept.
- R11: The count never goes below zero: in decrement mode, any number of false samples leaves it at zero, and exactly N true samples are then needed.
- R12: After reset, `event_act`, `axis_flag_out`, `axis_pol_out` and `wake_rst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe per sample period |
| cond_in | input | 1 | Combined condition for the current sample |
| axis_hit | input | NAXES | Per-axis hit bits for the current sample |
| axis_pol_in | input | NAXES | Per-axis polarity bits for the current sample |
| dbc_count | input | CNT_W | Debounce count N |
| dbc_clear_mode | input | 1 | 0: decrement on false sample, 1: clear on false sample |
| latch_en | input | 1 | Latched mode enable |
| wake_en | input | 1 | Keep-awake pulse enable |
| rd_clr | input | 1 | Host status-read clear pulse |
| mode_chg | input | 1 | Operating-mode change pulse |
| event_act | output | 1 | Debounced event-active flag |
| axis_flag_out | output | NAXES | Reported per-axis flags |
| axis_pol_out | output | NAXES | Reported per-axis polarity |
| wake_rst | output | 1 | Wake-timer reset pulse |

## Verification
A table of true/false sample sequences at N=3 in decrement mode separates the two count behaviours. Isolated false samples inside a run, short true bursts and a long false tail show whether the count steps down, clears or clamps, and whether the drop comes on the (N+1)th false sample. Directed sequences then cover:
- a false sample followed by a true one in clear mode;
- a long false run before the true samples;
- a read-clear pulse while the condition is still true in latched mode, and the same pulse in the clock of a set;
- the mode-change pulse alone and together with a strobe;
- count zero, where the flags follow the hits on every sample;
- a flag held high while the polarity input changes, which tests whether polarity is captured only on the rising edge of its flag.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
    typedef enum logic {
        CNT_DECR  = 1'b0,
        CNT_CLEAR = 1'b1
    } cnt_mode_e;
endpackage

// File: rtl/dbe_counter.sv
module dbe_counter
    import dbe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             cond_i,
    input  logic             mchg_i,
    input  logic             clr_mode_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             reached_o,
    output logic             zero_o
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [EXT_W-1:0] inc;
    logic [EXT_W-1:0] lim_ext;

    always_comb begin
        st_d      = st_q;
        inc       = {1'b0, st_q.cnt} + EXT_W'(1);
        lim_ext   = {1'b0, limit_i};
        zero_o    = (st_q.cnt == '0);
        reached_o = stb_i && cond_i && !mchg_i && (inc >= lim_ext);
        if (mchg_i) begin
            st_d.cnt = '0;
        end else if (stb_i) begin
            if (cond_i) begin
                st_d.cnt = (inc > lim_ext) ? limit_i : inc[CNT_W-1:0];
            end else if (clr_mode_i == CNT_CLEAR) begin
                st_d.cnt = '0;
            end else if (!zero_o) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !cond_i && !mchg_i && st_q.cnt == '0) |=> st_q.cnt == '0);
    p_mode_chg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_i |=> st_q.cnt == '0);
    p_clear_on_false_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !cond_i && clr_mode_i) |=> st_q.cnt == '0);
    p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && cond_i && !mchg_i) |=> st_q.cnt <= $past(limit_i));
endmodule

// File: rtl/dbe_event.sv
module dbe_event (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic cond_i,
    input  logic mchg_i,
    input  logic clr_mode_i,
    input  logic latch_i,
    input  logic rd_clr_i,
    input  logic wake_en_i,
    input  logic reached_i,
    input  logic zero_i,
    output logic act_o,
    output logic set_o,
    output logic wake_o
);
    typedef struct packed {
        logic act;
        logic armed;
        logic wake;
    } ev_st_t;

    ev_st_t st_d, st_q;
    logic   false_smp;

    always_comb begin
        st_d      = st_q;
        false_smp = stb_i && !cond_i && !mchg_i;
        set_o     = reached_i && (!latch_i || st_q.armed);
        if (set_o) begin
            st_d.act = 1'b1;
        end else if (latch_i) begin
            if (rd_clr_i) st_d.act = 1'b0;
        end else if (false_smp && (clr_mode_i || zero_i)) begin
            st_d.act = 1'b0;
        end
        if (set_o)          st_d.armed = 1'b0;
        else if (false_smp) st_d.armed = 1'b1;
        st_d.wake = stb_i && wake_en_i && st_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{act: 1'b0, armed: 1'b1, wake: 1'b0};
        else        st_q <= st_d;
    end

    assign act_o  = st_q.act;
    assign wake_o = st_q.wake;

    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && act_o && !rd_clr_i) |=> act_o);
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && rd_clr_i && set_o) |=> act_o);
    p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(act_o) && $past(stb_i));
    p_unlatched_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_i && act_o && !(stb_i && !cond_i)) |=> act_o);
endmodule

// File: rtl/dbe_flags.sv
module dbe_flags #(
    parameter int NAXES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             mchg_i,
    input  logic             lim_zero_i,
    input  logic             latch_i,
    input  logic             rd_clr_i,
    input  logic             set_i,
    input  logic [NAXES-1:0] hit_i,
    input  logic [NAXES-1:0] pol_i,
    output logic [NAXES-1:0] flag_o,
    output logic [NAXES-1:0] pol_o
);
    typedef struct packed {
        logic [NAXES-1:0] flag;
        logic [NAXES-1:0] pol;
    } fl_st_t;

    fl_st_t st_d, st_q;
    logic   upd;

    always_comb begin
        st_d = st_q;
        upd  = set_i || (stb_i && !mchg_i && lim_zero_i);
        if (latch_i) begin
            st_d.flag = (rd_clr_i ? '0 : st_q.flag) | (set_i ? hit_i : '0);
        end else if (upd) begin
            st_d.flag = hit_i;
        end
        for (int i = 0; i < NAXES; i++) begin
            if (st_d.flag[i] && !st_q.flag[i]) st_d.pol[i] = pol_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign pol_o  = st_q.pol;

    p_latched_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && !rd_clr_i) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    for (genvar g = 0; g < NAXES; g++) begin : g_pol_chk
        p_pol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && st_d.flag[g]) |=> $stable(pol_o[g]));
    end
endmodule

// File: rtl/dbnc_event_flag.sv
module dbnc_event_flag #(
    parameter int NAXES = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic             cond_in,
    input  logic [NAXES-1:0] axis_hit,
    input  logic [NAXES-1:0] axis_pol_in,
    input  logic [CNT_W-1:0] dbc_count,
    input  logic             dbc_clear_mode,
    input  logic             latch_en,
    input  logic             wake_en,
    input  logic             rd_clr,
    input  logic             mode_chg,
    output logic             event_act,
    output logic [NAXES-1:0] axis_flag_out,
    output logic [NAXES-1:0] axis_pol_out,
    output logic             wake_rst
);
    logic reached, cnt_zero, ev_set, lim_zero;

    assign lim_zero = (dbc_count == '0);

    dbe_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .stb_i(smp_stb), .cond_i(cond_in),
        .mchg_i(mode_chg), .clr_mode_i(dbc_clear_mode), .limit_i(dbc_count),
        .reached_o(reached), .zero_o(cnt_zero)
    );

    dbe_event u_ev (
        .clk(clk), .rst_n(rst_n), .stb_i(smp_stb), .cond_i(cond_in),
        .mchg_i(mode_chg), .clr_mode_i(dbc_clear_mode), .latch_i(latch_en),
        .rd_clr_i(rd_clr), .wake_en_i(wake_en), .reached_i(reached),
        .zero_i(cnt_zero), .act_o(event_act), .set_o(ev_set), .wake_o(wake_rst)
    );

    dbe_flags #(.NAXES(NAXES)) u_fl (
        .clk(clk), .rst_n(rst_n), .stb_i(smp_stb), .mchg_i(mode_chg),
        .lim_zero_i(lim_zero), .latch_i(latch_en), .rd_clr_i(rd_clr),
        .set_i(ev_set), .hit_i(axis_hit), .pol_i(axis_pol_in),
        .flag_o(axis_flag_out), .pol_o(axis_pol_out)
    );

    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |=> !wake_rst || $past(smp_stb));
endmodule

// File: tb/sim_dbnc_event_flag.sv
module sim_dbnc_event_flag;
    logic       clk = 1'b0;
    logic       rst_n, stb, cond, cmode, latch, wen, rd, mchg;
    logic [2:0] hit, pol;
    logic [7:0] cnt;
    logic       act, wake;
    logic [2:0] flg, polo;
    int         total = 0;
    int         fails = 0;

    // row: {cond, expected event_act}, N=3, decrement mode, unlatched
    localparam logic [1:0] VEC [19] = '{
        2'b10, 2'b10, 2'b11, 2'b01, 2'b01, 2'b01, 2'b00, 2'b10, 2'b00, 2'b10,
        2'b10, 2'b11, 2'b11, 2'b01, 2'b11, 2'b01, 2'b01, 2'b01, 2'b00
    };

    always #5 clk = ~clk;

    dbnc_event_flag u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(stb), .cond_in(cond), .axis_hit(hit),
        .axis_pol_in(pol), .dbc_count(cnt), .dbc_clear_mode(cmode), .latch_en(latch),
        .wake_en(wen), .rd_clr(rd), .mode_chg(mchg), .event_act(act),
        .axis_flag_out(flg), .axis_pol_out(polo), .wake_rst(wake)
    );

    task automatic chk(input string tag, input logic [7:0] a, input logic [7:0] e);
        total++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic do_reset(input logic [7:0] n, input logic cm, input logic la);
        @(negedge clk);
        rst_n = 1'b0; stb = 0; cond = 0; rd = 0; mchg = 0; hit = '0; pol = '0;
        wen = 0; cnt = n; cmode = cm; latch = la;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic c, input logic [2:0] h, input logic [2:0] p,
                        input logic rc, input logic mc);
        @(negedge clk);
        cond = c; hit = h; pol = p; rd = rc; mchg = mc; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0; rd = 1'b0; mchg = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R12 reset state
        do_reset(8'd3, 1'b0, 1'b0);
        chk("R12 act", {7'b0, act}, 0);
        chk("R12 flags", {5'b0, flg}, 0);
        chk("R12 pol", {5'b0, polo}, 0);
        chk("R12 wake", {7'b0, wake}, 0);

        // R1 / R2 table walk
        for (int i = 0; i < 19; i++) begin
            step(VEC[i][1], 3'b101, 3'b000, 1'b0, 1'b0);
            chk($sformatf("R1_R2 row%0d act", i), {7'b0, act}, {7'b0, VEC[i][0]});
        end
        chk("R6 flags after table", {5'b0, flg}, 8'h5);

        // R3 clear mode
        do_reset(8'd2, 1'b1, 1'b0);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        chk("R3 set", {7'b0, act}, 1);
        step(0, 0, 0, 0, 0);
        chk("R3 drop on one false", {7'b0, act}, 0);
        step(1, 0, 0, 0, 0);
        chk("R3 restart needs N", {7'b0, act}, 0);
        step(1, 0, 0, 0, 0);
        chk("R3 reset after N", {7'b0, act}, 1);

        // R11 no underflow
        do_reset(8'd2, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        chk("R11 first true", {7'b0, act}, 0);
        step(1, 0, 0, 0, 0);
        chk("R11 second true", {7'b0, act}, 1);

        // R8 mode change with strobe
        do_reset(8'd3, 1'b0, 1'b0);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        chk("R8 strobe ignored", {7'b0, act}, 0);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        chk("R8 count restarted", {7'b0, act}, 0);
        step(1, 0, 0, 0, 0);
        chk("R8 set after N", {7'b0, act}, 1);

        // R4 / R5 / R7 latched
        do_reset(8'd2, 1'b0, 1'b1);
        step(1, 3'b001, 3'b000, 0, 0);
        step(1, 3'b011, 3'b010, 0, 0);
        chk("R4 set", {7'b0, act}, 1);
        chk("R5 flags", {5'b0, flg}, 8'h3);
        chk("R7 pol capture", {5'b0, polo}, 8'h2);
        step(0, 3'b000, 3'b000, 0, 0);
        chk("R4 hold on false", {7'b0, act}, 1);
        chk("R5 flags held", {5'b0, flg}, 8'h3);
        step(1, 3'b100, 3'b100, 0, 0);
        chk("R5 flags or", {5'b0, flg}, 8'h7);
        chk("R7 pol new axis", {5'b0, polo}, 8'h6);
        pulse_rd();
        chk("R4 read clears act", {7'b0, act}, 0);
        chk("R5 read clears flags", {5'b0, flg}, 0);
        step(1, 3'b001, 0, 0, 0); step(1, 3'b001, 0, 0, 0);
        chk("R4 no reassert without false", {7'b0, act}, 0);
        step(0, 0, 0, 0, 0);
        step(1, 3'b001, 0, 0, 0);
        chk("R4 reassert after false", {7'b0, act}, 1);
        chk("R5 flags new event", {5'b0, flg}, 8'h1);

        // R10 set wins over read
        pulse_rd();
        step(0, 0, 0, 0, 0);
        step(1, 3'b100, 0, 1, 0);
        chk("R10 act", {7'b0, act}, 1);
        chk("R10 flags", {5'b0, flg}, 8'h4);

        // R5 unlatched read has no effect
        do_reset(8'd1, 1'b0, 1'b0);
        step(1, 3'b110, 0, 0, 0);
        pulse_rd();
        chk("R5 unlatched act", {7'b0, act}, 1);
        chk("R5 unlatched flags", {5'b0, flg}, 8'h6);

        // R6 count zero follows hits
        do_reset(8'd0, 1'b0, 1'b0);
        step(0, 3'b010, 0, 0, 0);
        chk("R6 follow false", {5'b0, flg}, 8'h2);
        chk("R6 act low", {7'b0, act}, 0);
        step(1, 3'b100, 0, 0, 0);
        chk("R6 follow true", {5'b0, flg}, 8'h4);
        chk("R1 count zero sets", {7'b0, act}, 1);
        step(0, 3'b000, 0, 0, 0);
        chk("R6 clears", {5'b0, flg}, 0);

        // R7 polarity hold
        step(1, 3'b001, 3'b001, 0, 0);
        chk("R7 capture", {7'b0, polo[0]}, 1);
        step(1, 3'b001, 3'b000, 0, 0);
        chk("R7 held", {7'b0, polo[0]}, 1);
        step(0, 3'b000, 3'b000, 0, 0);
        step(1, 3'b001, 3'b000, 0, 0);
        chk("R7 recapture", {7'b0, polo[0]}, 0);

        // R9 wake pulse
        do_reset(8'd1, 1'b0, 1'b0);
        wen = 1'b1;
        step(1, 0, 0, 0, 0);
        chk("R9 no wake on set sample", {7'b0, wake}, 0);
        step(1, 0, 0, 0, 0);
        chk("R9 wake pulse", {7'b0, wake}, 1);
        @(negedge clk);
        chk("R9 one cycle", {7'b0, wake}, 0);
        wen = 1'b0;
        step(1, 0, 0, 0, 0);
        chk("R9 disabled", {7'b0, wake}, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule